// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one column command into the column addresses for a double-data-rate burst. A command gives a starting column, a burst length and a wrap order. The block then presents two column addresses on every clock: one for the beat on the rising edge and one for the beat on the falling edge. It marks the final clock of the burst, and a new command or a terminate input can end the burst early. Column addresses are 8 bits wide, so each row page holds 256 columns.

A burst of 2, 4 or 8 beats wraps inside an aligned block of that size. The order inside the block is either sequential (the address counts up) or interleaved (the start address XOR the beat number). A full-page burst wraps over all 256 columns and keeps running until another command or a terminate ends it. For write bursts the block also turns the four per-byte mask inputs into byte write enables in the same cycle. A high mask bit blocks its byte.

Top module: `bcg_burst_colgen`

## Requirements
- R1: While reset is low, and in the first cycle after it goes high, `beat_valid` is 0 and `byte_we` is 0.
- R2: The `blen` code is 0=2 beats, 1=4, 2=8, 3=full page, and `wrap_il`=0 selects sequential order. Let m = BL-1 and let j be the beat number. In sequential order, beat j has address (s & ~m) | ((s + j) & m), where s is the start column. `col_even` carries beat 2i and `col_odd` carries beat 2i+1 in the i-th clock of the burst.
- R3: When `wrap_il`=1, beat j has address s ^ (j & m).
- R4: When `start` is sampled high, `beat_valid` rises in the next cycle with beat pair 0. A burst of BL = 2, 4 or 8 lasts BL/2 cycles. `beat_last` is high only in the final cycle, and `beat_valid` is 0 in the cycle after it unless a new command was taken.
- R5: A full-page burst uses m = 255. It runs past 128 cycles, with the beat number taken modulo 256, and it never raises `beat_last`.
- R6: A `start` sampled during a burst ends that burst. The next cycle shows pair 0 of the new burst.
- R7: A `term` sampled high ends the burst, so `beat_valid` is 0 in the next cycle. If `start` is high in the same cycle, `start` wins.
- R8: In a valid cycle of a write burst (`wr_cmd` captured high), `byte_we[k]` = ~`dm[k]` in the same cycle. In all other cycles `byte_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Column command strobe |
| start_col | input | 8 | Starting column of the command |
| blen | input | 2 | Burst length code (0:2, 1:4, 2:8, 3:full page) |
| wrap_il | input | 1 | 1 selects interleaved order, 0 sequential |
| wr_cmd | input | 1 | 1 marks the command as a write |
| term | input | 1 | Ends the running burst |
| dm | input | 4 | Per-byte write mask, high blocks the byte |
| col_even | output | 8 | Column of the rising-edge beat |
| col_odd | output | 8 | Column of the falling-edge beat |
| beat_valid | output | 1 | A beat pair is presented this cycle |
| beat_last | output | 1 | This is the final pair of a fixed-length burst |
| byte_we | output | 4 | Byte write enables for this cycle |

## Verification
The bench uses start columns that sit away from block alignment, so an odd start or a mid-block start must wrap back to the bottom of its block. A design that carried into the upper address bits would show a wrong column in the second half of the burst. A full-page burst is run for 130 cycles, which takes it past both the 255-to-0 column wrap and the wrap of the internal pair counter. A design that stopped or raised a last flag there would be caught. Restarts in mid-burst, a terminate on its own, and a terminate together with a new command check that the old burst disappears and the new one begins with pair 0 exactly one cycle later. A changing mask on every cycle exposes any enable that is registered, inverted, or active during read or idle cycles.

// File: rtl/bcg_pkg.sv
`timescale 1ns/1ps
// Shared types for the burst column generator.
package bcg_pkg;
    typedef enum logic [1:0] {
        BL_TWO   = 2'd0,
        BL_FOUR  = 2'd1,
        BL_EIGHT = 2'd2,
        BL_PAGE  = 2'd3
    } blen_e;
endpackage

// File: rtl/bcg_seq_ctrl.sv
`timescale 1ns/1ps
// Burst sequencer: captures a command, counts beat pairs and flags the end.
// Assumes start has priority over term, and term over natural completion.
module bcg_seq_ctrl
    import bcg_pkg::*;
#(
    parameter int COL_W  = 8,
    localparam int PAIR_W = COL_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic [1:0]        blen,
    input  logic              wrap_il,
    input  logic              wr_cmd,
    input  logic              term,
    output logic              active,
    output logic              last,
    output logic [COL_W-1:0]  base,
    output logic [PAIR_W-1:0] pair_idx,
    output blen_e             blen_q,
    output logic              il_q,
    output logic              wr_q
);
    // Final pair of a fixed-length burst: index reaches BL/2 - 1.
    always_comb begin
        last = active && (blen_q != BL_PAGE) &&
               (pair_idx == PAIR_W'((1 << blen_q) - 1));
    end

    // Command capture, pair counting and burst termination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            pair_idx <= '0;
            base     <= '0;
            blen_q   <= BL_TWO;
            il_q     <= 1'b0;
            wr_q     <= 1'b0;
        end else if (start) begin
            active   <= 1'b1;
            pair_idx <= '0;
            base     <= start_col;
            blen_q   <= blen_e'(blen);
            il_q     <= wrap_il;
            wr_q     <= wr_cmd;
        end else if (term || last) begin
            active   <= 1'b0;
            pair_idx <= '0;
        end else if (active) begin
            pair_idx <= pair_idx + 1'b1;
        end
    end
endmodule

// File: rtl/bcg_lane_addr.sv
`timescale 1ns/1ps
// Column for one edge lane: beat = {pair index, LANE}, wrapped by burst size.
// Assumes full page wraps over the whole COL_W-bit column space.
module bcg_lane_addr
    import bcg_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter bit LANE   = 1'b0,
    localparam int PAIR_W = COL_W - 1
) (
    input  logic [COL_W-1:0]  base,
    input  logic [PAIR_W-1:0] pair_idx,
    input  blen_e             blen_q,
    input  logic              il_q,
    output logic [COL_W-1:0]  col
);
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] wmask;

    // Wrap mask and address for this lane.
    always_comb begin
        beat  = {pair_idx, LANE};
        wmask = (blen_q == BL_PAGE) ? '1 : COL_W'((1 << (blen_q + 1)) - 1);
        if (il_q)
            col = base ^ (beat & wmask);
        else
            col = (base & ~wmask) | ((base + beat) & wmask);
    end
endmodule

// File: rtl/bcg_mask.sv
`timescale 1ns/1ps
// Byte write enables: zero-latency, a high mask bit blocks its byte.
module bcg_mask #(
    parameter int BYTES = 4
) (
    input  logic             active,
    input  logic             wr_q,
    input  logic [BYTES-1:0] dm,
    output logic [BYTES-1:0] byte_we
);
    // Enable only during valid write beats.
    always_comb begin
        byte_we = (active && wr_q) ? ~dm : '0;
    end
endmodule

// File: rtl/bcg_burst_colgen.sv
`timescale 1ns/1ps
// Burst column address generator: two columns per clock for a DDR burst.
// Assumes one command at a time; a new command replaces the running burst.
module bcg_burst_colgen
    import bcg_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int BYTES = 4,
    localparam int PAIR_W = COL_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [1:0]       blen,
    input  logic             wrap_il,
    input  logic             wr_cmd,
    input  logic             term,
    input  logic [BYTES-1:0] dm,
    output logic [COL_W-1:0] col_even,
    output logic [COL_W-1:0] col_odd,
    output logic             beat_valid,
    output logic             beat_last,
    output logic [BYTES-1:0] byte_we
);
    logic              active;
    logic              last;
    logic [COL_W-1:0]  base;
    logic [PAIR_W-1:0] pair_idx;
    blen_e             blen_q;
    logic              il_q;
    logic              wr_q;
    logic [COL_W-1:0]  lane_col [2];

    bcg_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .blen(blen), .wrap_il(wrap_il), .wr_cmd(wr_cmd), .term(term),
        .active(active), .last(last), .base(base), .pair_idx(pair_idx),
        .blen_q(blen_q), .il_q(il_q), .wr_q(wr_q)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        bcg_lane_addr #(.COL_W(COL_W), .LANE(g[0])) u_lane (
            .base(base), .pair_idx(pair_idx), .blen_q(blen_q),
            .il_q(il_q), .col(lane_col[g])
        );
    end

    bcg_mask #(.BYTES(BYTES)) u_mask (
        .active(active), .wr_q(wr_q), .dm(dm), .byte_we(byte_we)
    );

    // Output mapping.
    always_comb begin
        col_even   = lane_col[0];
        col_odd    = lane_col[1];
        beat_valid = active;
        beat_last  = last;
    end
endmodule

// File: rtl/bcg_burst_colgen_chk.sv
`timescale 1ns/1ps
// Protocol checker for the burst column generator, bound to the top.
module bcg_burst_colgen_chk #(
    parameter int COL_W = 8,
    parameter int BYTES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             term,
    input logic [BYTES-1:0] dm,
    input logic [COL_W-1:0] col_even,
    input logic [COL_W-1:0] col_odd,
    input logic             beat_valid,
    input logic             beat_last,
    input logic [BYTES-1:0] byte_we
);
    // R2: the two lanes of a pair always differ in column bit 0.
    a_r2_lane_parity: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (col_even[0] != col_odd[0]));

    // R4: a last pair without a new command is followed by an idle cycle.
    a_r4_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_last && !start) |=> !beat_valid);

    // R4: last is never flagged outside a valid cycle.
    a_r4_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

    // R6: a command always opens a burst in the next cycle.
    a_r6_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> beat_valid);

    // R7: terminate without a command closes the burst.
    a_r7_term_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !start) |=> !beat_valid);

    // R8: no enables outside valid cycles, and a masked byte is never enabled.
    a_r8_idle_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |-> (byte_we == '0));

    a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> ((byte_we & dm) == '0));
endmodule

bind bcg_burst_colgen bcg_burst_colgen_chk #(.COL_W(COL_W), .BYTES(BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .term(term), .dm(dm),
    .col_even(col_even), .col_odd(col_odd), .beat_valid(beat_valid),
    .beat_last(beat_last), .byte_we(byte_we)
);

// File: tb/bcg_burst_colgen_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected beat pairs, the monitor compares.
module bcg_burst_colgen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic [1:0] blen = '0;
    logic       wrap_il = 1'b0;
    logic       wr_cmd = 1'b0;
    logic       term = 1'b0;
    logic [3:0] dm = '0;
    logic [7:0] col_even, col_odd;
    logic       beat_valid, beat_last;
    logic [3:0] byte_we;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] ev;
        logic [7:0] od;
        logic       last;
        logic       wr;
        string      tag;
    } exp_t;
    exp_t q[$];

    bcg_burst_colgen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .blen(blen), .wrap_il(wrap_il), .wr_cmd(wr_cmd), .term(term),
        .dm(dm), .col_even(col_even), .col_odd(col_odd),
        .beat_valid(beat_valid), .beat_last(beat_last), .byte_we(byte_we)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Expected column of beat j (requirements R2, R3, R5).
    function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [1:0] bl,
                                           input bit il, input int j);
        logic [7:0] m, jb;
        m  = (bl == 2'd3) ? 8'hFF : 8'((2 << bl) - 1);
        jb = 8'(j);
        return il ? (s ^ (jb & m)) : ((s & ~m) | ((s + jb) & m));
    endfunction

    // Mask stimulus changes every cycle, away from the sampling edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            dm = dm + 4'd5;
        end
    end

    // Monitor: compares every valid cycle against the queue.
    always @(negedge clk) begin
        if (rst_n && !done && beat_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R4", "unexpected beat", 32'(col_even), 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(col_even == e.ev, e.tag, "col_even", 32'(col_even), 32'(e.ev));
                check(col_odd == e.od, e.tag, "col_odd", 32'(col_odd), 32'(e.od));
                check(beat_last == e.last, "R4", "beat_last", 32'(beat_last), 32'(e.last));
                check(byte_we == (e.wr ? ~dm : 4'h0), "R8", "byte_we",
                      32'(byte_we), 32'(e.wr ? ~dm : 4'h0));
            end
        end
    end

    // Driver: starts a burst now and stays for n pair cycles.
    task automatic go(input logic [7:0] s, input logic [1:0] bl, input bit il,
                      input bit wr, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.ev   = exp_col(s, bl, il, 2 * k);
            e.od   = exp_col(s, bl, il, 2 * k + 1);
            e.last = (bl != 2'd3) && (k == (1 << bl) - 1);
            e.wr   = wr;
            e.tag  = tag;
            q.push_back(e);
        end
        start = 1'b1; start_col = s; blen = bl; wrap_il = il; wr_cmd = wr;
        @(posedge clk); #1;
        start = 1'b0; term = 1'b0;
        for (int k = 1; k < n; k++) begin
            @(posedge clk); #1;
        end
    endtask

    // Idle cycle: nothing valid, no enables, no pending beats.
    task automatic idle_check(input string tag);
        @(negedge clk);
        check(beat_valid == 1'b0, tag, "valid after end", 32'(beat_valid), 32'h0);
        check(byte_we == 4'h0, "R8", "idle byte_we", 32'(byte_we), 32'h0);
        check(q.size() == 0, tag, "missing beats", 32'(q.size()), 32'h0);
        @(posedge clk); #1;
    endtask

    task automatic end_natural(input string tag);
        @(posedge clk); #1;
        idle_check(tag);
    endtask

    task automatic end_term();
        term = 1'b1;
        @(posedge clk); #1;
        term = 1'b0;
        idle_check("R7");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(beat_valid == 1'b0, "R1", "valid in reset", 32'(beat_valid), 32'h0);
        check(byte_we == 4'h0, "R1", "byte_we in reset", 32'(byte_we), 32'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(beat_valid == 1'b0, "R1", "valid after reset", 32'(beat_valid), 32'h0);
        check(byte_we == 4'h0, "R1", "byte_we after reset", 32'(byte_we), 32'h0);
        @(posedge clk); #1;

        // Sequential, fixed lengths, misaligned starts (R2, R4).
        go(8'h15, 2'd0, 1'b0, 1'b0, 1, "R2"); end_natural("R4");
        go(8'h2E, 2'd1, 1'b0, 1'b1, 2, "R2"); end_natural("R4");
        go(8'h5B, 2'd2, 1'b0, 1'b1, 4, "R2"); end_natural("R4");
        // Interleaved (R3).
        go(8'h37, 2'd1, 1'b1, 1'b0, 2, "R3"); end_natural("R4");
        go(8'hA5, 2'd2, 1'b1, 1'b1, 4, "R3"); end_natural("R4");
        go(8'h40, 2'd0, 1'b1, 1'b1, 1, "R3"); end_natural("R4");
        // Full page past both wraps, then terminate (R5, R7).
        go(8'hF0, 2'd3, 1'b0, 1'b1, 130, "R5"); end_term();
        // Interleaved full page restarted by a fixed burst (R5, R6).
        go(8'h3C, 2'd3, 1'b1, 1'b1, 5, "R5");
        go(8'h81, 2'd2, 1'b0, 1'b0, 4, "R6"); end_natural("R6");
        // Fixed burst interrupted by a new command (R6).
        go(8'h10, 2'd2, 1'b0, 1'b1, 2, "R2");
        go(8'h6D, 2'd1, 1'b1, 1'b0, 2, "R6"); end_natural("R6");
        // Terminate mid burst (R7).
        go(8'h99, 2'd2, 1'b1, 1'b1, 2, "R3"); end_term();
        // Terminate and command together: command wins (R7).
        go(8'h20, 2'd2, 1'b0, 1'b0, 3, "R2");
        term = 1'b1;
        go(8'h47, 2'd0, 1'b0, 1'b1, 1, "R7"); end_natural("R7");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(5 * 200000);
        total++;
        bad++;
        $display("FAIL R4 watchdog act=%h exp=%h", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule